// File: doc/BRIEF.md
# Integer Execution Unit with Overflow Trap

This block is the purely combinational integer datapath of a simple 32-bit core. Each cycle the issue logic presents it with:

- the primary opcode and the function field of one instruction;
- the fixed shift-amount field and the 16-bit immediate;
- the two register operands read for that instruction.

In the same cycle the block returns the value to be written back. It also raises two flags:

- an overflow-trap flag, for the arithmetic forms that trap;
- a reserved-instruction flag, for encodings it does not implement.

The block covers the register-register arithmetic, logic, compare and shift group, plus the immediate arithmetic, logic, compare and load-upper group. For each immediate opcode it picks the immediate extension itself:

- sign extension for the add and compare forms;
- zero extension for the bitwise forms.

Signed overflow is trapped only for the trapping add and subtract forms. The wrapping forms produce the same sum and never flag. When the trap flag is high, the result is still driven, but the surrounding pipeline must not write it back.

The design has no clock and no storage. It is built from three parts:

- a decoder that maps the two code fields to an operation kind and operand controls;
- a shared adder/subtractor that also produces the compare outcomes;
- a barrel shifter.

Top module: `int_exec_alu`

## Requirements
- R1: With opcode 000000, function 100000 returns rs+rt and function 100010 returns rs-rt, both modulo 2^32.
- R2: The function codes 100000 and 100010, and opcode 001000 (rs plus the sign-extended immediate), raise `ovf_trap` exactly when the signed result overflows. The wrapped result is still driven.
- R3: Function codes 100001 (add) and 100011 (subtract), and opcode 001001 (add sign-extended immediate), never raise `ovf_trap`. They return the same wrapped sums as the trapping forms.
- R4: Function codes 100100, 100101, 100110 and 100111 return rs AND rt, rs OR rt, rs XOR rt and NOT(rs OR rt) respectively.
- R5: Opcodes 001100, 001101 and 001110 combine rs with the zero-extended immediate by AND, OR and XOR respectively.
- R6: Two forms compare as signed: function 101010 (rs against rt) and opcode 001010 (rs against the sign-extended immediate). Two forms compare as unsigned: function 101011 (rs against rt) and opcode 001011 (rs against the sign-extended immediate). Each returns 1 when rs is the lesser and 0 otherwise.
- R7: Opcode 001111 returns the immediate in bits 31..16 and zeros in bits 15..0, whatever rs holds.
- R8: Function codes 000000, 000010 and 000011 shift rt by the `shamt` field. Function codes 000100, 000110 and 000111 shift rt by rs[4:0], ignoring the rest of rs and the `shamt` field. In each group the codes mean left, logical right and arithmetic right, in that order.
- R9: The logical right shifts fill vacated high bits with zeros. The arithmetic right shifts fill them with copies of rt[31].
- R10: Any other opcode, or any other function code under opcode 000000, returns a zero result with `rsvd_instr` high and `ovf_trap` low. Every implemented encoding holds `rsvd_instr` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 6 | Primary opcode field |
| fn_code | input | 6 | Function field, used when op_code is 000000 |
| shamt | input | 5 | Fixed shift-amount field |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| result | output | 32 | Value to write back |
| ovf_trap | output | 1 | Signed overflow on a trapping add or subtract form |
| rsvd_instr | output | 1 | Encoding not implemented |

## Verification
The bench builds the block with its default 32-bit data width and 16-bit immediate. Operands therefore sit exactly at the signed limits 0x7FFFFFFF and 0x80000000, which exercises overflow in both directions for register and immediate forms. The 5-bit shift amount reaches the full range up to 31. The same width puts an all-ones immediate within reach of the unsigned compare, where sign extension makes it the largest unsigned value.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [3:0] {
        K_ADD,
        K_SUB,
        K_AND,
        K_OR,
        K_XOR,
        K_NOR,
        K_SLT,
        K_SLTU,
        K_SLL,
        K_SRL,
        K_SRA,
        K_LUI,
        K_BAD
    } op_kind_e;

    localparam logic [5:0] OPC_REG   = 6'b000000;
    localparam logic [5:0] OPC_ADDI  = 6'b001000;
    localparam logic [5:0] OPC_ADDIU = 6'b001001;
    localparam logic [5:0] OPC_SLTI  = 6'b001010;
    localparam logic [5:0] OPC_SLTIU = 6'b001011;
    localparam logic [5:0] OPC_ANDI  = 6'b001100;
    localparam logic [5:0] OPC_ORI   = 6'b001101;
    localparam logic [5:0] OPC_XORI  = 6'b001110;
    localparam logic [5:0] OPC_LUI   = 6'b001111;

    localparam logic [5:0] FN_SLL  = 6'b000000;
    localparam logic [5:0] FN_SRL  = 6'b000010;
    localparam logic [5:0] FN_SRA  = 6'b000011;
    localparam logic [5:0] FN_SLLV = 6'b000100;
    localparam logic [5:0] FN_SRLV = 6'b000110;
    localparam logic [5:0] FN_SRAV = 6'b000111;
    localparam logic [5:0] FN_ADD  = 6'b100000;
    localparam logic [5:0] FN_ADDU = 6'b100001;
    localparam logic [5:0] FN_SUB  = 6'b100010;
    localparam logic [5:0] FN_SUBU = 6'b100011;
    localparam logic [5:0] FN_AND  = 6'b100100;
    localparam logic [5:0] FN_OR   = 6'b100101;
    localparam logic [5:0] FN_XOR  = 6'b100110;
    localparam logic [5:0] FN_NOR  = 6'b100111;
    localparam logic [5:0] FN_SLT  = 6'b101010;
    localparam logic [5:0] FN_SLTU = 6'b101011;

    typedef struct packed {
        op_kind_e kind;
        logic     use_imm;
        logic     imm_sext;
        logic     trap_en;
        logic     var_shift;
    } dec_ctl_t;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [5:0] op_code,
    input  logic [5:0] fn_code,
    output dec_ctl_t   ctl
);
    always_comb begin
        ctl = '{kind: K_BAD, use_imm: 1'b0, imm_sext: 1'b0,
                trap_en: 1'b0, var_shift: 1'b0};
        unique case (op_code)
            OPC_REG: begin
                unique case (fn_code)
                    FN_SLL:  ctl.kind = K_SLL;
                    FN_SRL:  ctl.kind = K_SRL;
                    FN_SRA:  ctl.kind = K_SRA;
                    FN_SLLV: begin ctl.kind = K_SLL; ctl.var_shift = 1'b1; end
                    FN_SRLV: begin ctl.kind = K_SRL; ctl.var_shift = 1'b1; end
                    FN_SRAV: begin ctl.kind = K_SRA; ctl.var_shift = 1'b1; end
                    FN_ADD:  begin ctl.kind = K_ADD; ctl.trap_en = 1'b1; end
                    FN_ADDU: ctl.kind = K_ADD;
                    FN_SUB:  begin ctl.kind = K_SUB; ctl.trap_en = 1'b1; end
                    FN_SUBU: ctl.kind = K_SUB;
                    FN_AND:  ctl.kind = K_AND;
                    FN_OR:   ctl.kind = K_OR;
                    FN_XOR:  ctl.kind = K_XOR;
                    FN_NOR:  ctl.kind = K_NOR;
                    FN_SLT:  ctl.kind = K_SLT;
                    FN_SLTU: ctl.kind = K_SLTU;
                    default: ctl.kind = K_BAD;
                endcase
            end
            OPC_ADDI: begin
                ctl.kind = K_ADD; ctl.use_imm = 1'b1;
                ctl.imm_sext = 1'b1; ctl.trap_en = 1'b1;
            end
            OPC_ADDIU: begin
                ctl.kind = K_ADD; ctl.use_imm = 1'b1; ctl.imm_sext = 1'b1;
            end
            OPC_SLTI: begin
                ctl.kind = K_SLT; ctl.use_imm = 1'b1; ctl.imm_sext = 1'b1;
            end
            OPC_SLTIU: begin
                ctl.kind = K_SLTU; ctl.use_imm = 1'b1; ctl.imm_sext = 1'b1;
            end
            OPC_ANDI: begin ctl.kind = K_AND; ctl.use_imm = 1'b1; end
            OPC_ORI:  begin ctl.kind = K_OR;  ctl.use_imm = 1'b1; end
            OPC_XORI: begin ctl.kind = K_XOR; ctl.use_imm = 1'b1; end
            OPC_LUI:  begin ctl.kind = K_LUI; ctl.use_imm = 1'b1; end
            default:  ctl.kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              ovf,
    output logic              lt_s,
    output logic              lt_u
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   wide;

    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
        sum   = wide[MSB:0];
        ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
        lt_s  = sum[MSB] ^ ovf;
        lt_u  = ~wide[DATA_W];
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int DATA_W = 32,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] val,
    input  logic [SH_W-1:0]   amt,
    input  logic              dir_right,
    input  logic              arith,
    output logic [DATA_W-1:0] out
);
    logic              fill;
    logic [DATA_W-1:0] lstg [SH_W+1];
    logic [DATA_W-1:0] rstg [SH_W+1];

    assign fill    = arith & val[DATA_W-1];
    assign lstg[0] = val;
    assign rstg[0] = val;

    for (genvar i = 0; i < SH_W; i++) begin : g_stage
        localparam int STEP = 2 ** i;
        assign lstg[i+1] = amt[i] ? {lstg[i][DATA_W-1-STEP:0], {STEP{1'b0}}}
                                  : lstg[i];
        assign rstg[i+1] = amt[i] ? {{STEP{fill}}, rstg[i][DATA_W-1:STEP]}
                                  : rstg[i];
    end

    assign out = dir_right ? rstg[SH_W] : lstg[SH_W];
endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [5:0]        op_code,
    input  logic [5:0]        fn_code,
    input  logic [SH_W-1:0]   shamt,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] result,
    output logic              ovf_trap,
    output logic              rsvd_instr
);
    localparam int PAD_W = DATA_W - IMM_W;

    dec_ctl_t          ctl;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] sum;
    logic              raw_ovf;
    logic              lt_s;
    logic              lt_u;
    logic [SH_W-1:0]   sh_amt;
    logic [DATA_W-1:0] sh_out;
    logic              is_sub;

    alu_decode u_dec (
        .op_code (op_code),
        .fn_code (fn_code),
        .ctl     (ctl)
    );

    assign imm_ext = ctl.imm_sext ? {{PAD_W{imm[IMM_W-1]}}, imm}
                                  : {{PAD_W{1'b0}}, imm};
    assign opnd_b  = ctl.use_imm ? imm_ext : rt_val;
    assign is_sub  = (ctl.kind != K_ADD);

    alu_addsub #(.DATA_W(DATA_W)) u_add (
        .a    (rs_val),
        .b    (opnd_b),
        .sub  (is_sub),
        .sum  (sum),
        .ovf  (raw_ovf),
        .lt_s (lt_s),
        .lt_u (lt_u)
    );

    assign sh_amt = ctl.var_shift ? rs_val[SH_W-1:0] : shamt;

    alu_shift #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shf (
        .val       (rt_val),
        .amt       (sh_amt),
        .dir_right (ctl.kind != K_SLL),
        .arith     (ctl.kind == K_SRA),
        .out       (sh_out)
    );

    always_comb begin
        result     = '0;
        ovf_trap   = 1'b0;
        rsvd_instr = 1'b0;
        unique case (ctl.kind)
            K_ADD, K_SUB: begin
                result   = sum;
                ovf_trap = ctl.trap_en & raw_ovf;
            end
            K_AND:  result = rs_val & opnd_b;
            K_OR:   result = rs_val | opnd_b;
            K_XOR:  result = rs_val ^ opnd_b;
            K_NOR:  result = ~(rs_val | opnd_b);
            K_SLT:  result = {{(DATA_W-1){1'b0}}, lt_s};
            K_SLTU: result = {{(DATA_W-1){1'b0}}, lt_u};
            K_SLL, K_SRL, K_SRA: result = sh_out;
            K_LUI:  result = {imm, {PAD_W{1'b0}}};
            default: rsvd_instr = 1'b1;
        endcase
    end
endmodule

// File: rtl/int_exec_alu_chk.sv
module int_exec_alu_chk #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input logic [5:0]        op_code,
    input logic [5:0]        fn_code,
    input logic [DATA_W-1:0] rs_val,
    input logic [IMM_W-1:0]  imm,
    input logic [DATA_W-1:0] result,
    input logic              ovf_trap,
    input logic              rsvd_instr
);
    logic is_reg;
    logic trap_form;
    logic wrap_form;
    logic cmp_form;

    assign is_reg    = (op_code == 6'b000000);
    assign trap_form = (is_reg && (fn_code == 6'b100000 || fn_code == 6'b100010))
                     || op_code == 6'b001000;
    assign wrap_form = (is_reg && (fn_code == 6'b100001 || fn_code == 6'b100011))
                     || op_code == 6'b001001;
    assign cmp_form  = (is_reg && (fn_code == 6'b101010 || fn_code == 6'b101011))
                     || op_code == 6'b001010 || op_code == 6'b001011;

    always_comb begin
        AST_OVF_ONLY_TRAP: assert (!ovf_trap || trap_form);                   // R2
        AST_NO_OVERFLOW:   assert (!(wrap_form && ovf_trap));                  // R3
        AST_CMP_BOOL:      assert (!cmp_form || result[DATA_W-1:1] == '0);     // R6
        AST_LUI_LOW:       assert (op_code != 6'b001111
                                   || result == {imm, {(DATA_W-IMM_W){1'b0}}}); // R7
        AST_ORI_HIGH:      assert (op_code != 6'b001101
                                   || result[DATA_W-1:IMM_W] == rs_val[DATA_W-1:IMM_W]); // R5
        AST_RSVD_QUIET:    assert (!rsvd_instr || (result == '0 && !ovf_trap)); // R10
    end
endmodule

bind int_exec_alu int_exec_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/sim_int_exec_alu.sv
module sim_int_exec_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  op_code = '0;
    logic [5:0]  fn_code = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [15:0] imm = '0;
    logic [31:0] result;
    logic        ovf_trap;
    logic        rsvd_instr;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        ovf;
        logic        rsv;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    int_exec_alu u0 (
        .op_code    (op_code),
        .fn_code    (fn_code),
        .shamt      (shamt),
        .rs_val     (rs_val),
        .rt_val     (rt_val),
        .imm        (imm),
        .result     (result),
        .ovf_trap   (ovf_trap),
        .rsvd_instr (rsvd_instr)
    );

    task automatic drive(input logic [5:0] op, input logic [5:0] fn,
                         input logic [4:0] sh, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] im,
                         input logic [31:0] er, input logic eo,
                         input logic ev, input string tag);
        exp_t e;
        @(posedge clk);
        op_code = op; fn_code = fn; shamt = sh;
        rs_val = a; rt_val = b; imm = im;
        e.res = er; e.ovf = eo; e.rsv = ev; e.tag = tag;
        sb.push_back(e);
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (result !== e.res || ovf_trap !== e.ovf || rsvd_instr !== e.rsv) begin
                bad++;
                $display("FAIL %s: got res=%h ovf=%b rsvd=%b exp res=%h ovf=%b rsvd=%b",
                         e.tag, result, ovf_trap, rsvd_instr, e.res, e.ovf, e.rsv);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // idle inputs (all zero) decode as shift-left by 0 of 0
        drive(6'h00, 6'h00, 5'd0, 32'h0, 32'h0, 16'h0, 32'h0, 0, 0, "R8 idle");
        // R1
        drive(6'h00, 6'b100000, 0, 32'd5, 32'd7, 0, 32'd12, 0, 0, "R1 add");
        drive(6'h00, 6'b100010, 0, 32'd3, 32'd5, 0, 32'hFFFFFFFE, 0, 0, "R1 sub");
        // R2
        drive(6'h00, 6'b100000, 0, 32'h7FFFFFFF, 32'd1, 0, 32'h80000000, 1, 0, "R2 add ovf");
        drive(6'h00, 6'b100010, 0, 32'h80000000, 32'd1, 0, 32'h7FFFFFFF, 1, 0, "R2 sub ovf");
        drive(6'b001000, 0, 0, 32'h7FFFFFF0, 0, 16'h0010, 32'h80000000, 1, 0, "R2 addi ovf");
        drive(6'b001000, 0, 0, 32'h80000000, 0, 16'hFFFF, 32'h7FFFFFFF, 1, 0, "R2 addi neg ovf");
        // R3
        drive(6'h00, 6'b100001, 0, 32'h7FFFFFFF, 32'd1, 0, 32'h80000000, 0, 0, "R3 addu");
        drive(6'h00, 6'b100011, 0, 32'h80000000, 32'd1, 0, 32'h7FFFFFFF, 0, 0, "R3 subu");
        drive(6'b001001, 0, 0, 32'h10, 0, 16'hFFFF, 32'h0000000F, 0, 0, "R3 addiu sext");
        drive(6'b001001, 0, 0, 32'h7FFFFFFF, 0, 16'h0001, 32'h80000000, 0, 0, "R3 addiu wrap");
        // R4
        drive(6'h00, 6'b100100, 0, 32'hF0F0F0F0, 32'hFF00FF00, 0, 32'hF000F000, 0, 0, "R4 and");
        drive(6'h00, 6'b100101, 0, 32'hF0F0F0F0, 32'hFF00FF00, 0, 32'hFFF0FFF0, 0, 0, "R4 or");
        drive(6'h00, 6'b100110, 0, 32'hF0F0F0F0, 32'hFF00FF00, 0, 32'h0FF00FF0, 0, 0, "R4 xor");
        drive(6'h00, 6'b100111, 0, 32'hF0F0F0F0, 32'hFF00FF00, 0, 32'h000F000F, 0, 0, "R4 nor");
        // R5
        drive(6'b001100, 0, 0, 32'hFFFFFFFF, 0, 16'h8001, 32'h00008001, 0, 0, "R5 andi");
        drive(6'b001101, 0, 0, 32'h12340000, 0, 16'h8000, 32'h12348000, 0, 0, "R5 ori");
        drive(6'b001110, 0, 0, 32'hFFFFFFFF, 0, 16'hFFFF, 32'hFFFF0000, 0, 0, "R5 xori");
        // R6
        drive(6'h00, 6'b101010, 0, 32'hFFFFFFFF, 32'd1, 0, 32'd1, 0, 0, "R6 slt");
        drive(6'h00, 6'b101011, 0, 32'hFFFFFFFF, 32'd1, 0, 32'd0, 0, 0, "R6 sltu");
        drive(6'b001010, 0, 0, 32'hFFFFFFFE, 0, 16'hFFFF, 32'd1, 0, 0, "R6 slti");
        drive(6'b001011, 0, 0, 32'd5, 0, 16'hFFFF, 32'd1, 0, 0, "R6 sltiu sext");
        drive(6'b001011, 0, 0, 32'hFFFFFFFF, 0, 16'hFFFF, 32'd0, 0, 0, "R6 sltiu equal");
        // R7
        drive(6'b001111, 0, 0, 32'hFFFFFFFF, 0, 16'hABCD, 32'hABCD0000, 0, 0, "R7 lui");
        // R8 / R9
        drive(6'h00, 6'b000000, 5'd31, 0, 32'd1, 0, 32'h80000000, 0, 0, "R8 sll");
        drive(6'h00, 6'b000010, 5'd4, 0, 32'h80000000, 0, 32'h08000000, 0, 0, "R9 srl");
        drive(6'h00, 6'b000011, 5'd4, 0, 32'h80000000, 0, 32'hF8000000, 0, 0, "R9 sra");
        drive(6'h00, 6'b000100, 5'd7, 32'h00000024, 32'd1, 0, 32'h00000010, 0, 0, "R8 sllv");
        drive(6'h00, 6'b000111, 5'd9, 32'hFFFFFFE1, 32'h80000000, 0, 32'hC0000000, 0, 0, "R9 srav");
        drive(6'h00, 6'b000110, 5'd0, 32'h00000003, 32'hF0000000, 0, 32'h1E000000, 0, 0, "R9 srlv");
        // R10
        drive(6'h00, 6'b000001, 0, 32'h7FFFFFFF, 32'd1, 0, 32'h0, 0, 1, "R10 bad fn");
        drive(6'h00, 6'b001000, 0, 32'h12345678, 32'd1, 0, 32'h0, 0, 1, "R10 jr fn");
        drive(6'b000010, 0, 0, 32'h12345678, 32'd1, 16'hFFFF, 32'h0, 0, 1, "R10 bad op");
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            if (sb.size() != 0) begin
                bad++;
                $display("FAIL scoreboard: got %0d left exp 0", sb.size());
            end
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule